// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block is a bus-attached parallel I/O peripheral. It has two independent ports, A and B, each `W` bits wide. A direction register sets every pin of a port to input or output, one bit per pin. Each port also has two control lines. Line 1 is always an input that raises an event on a selected edge. Line 2 can be an event input, a handshake output, a one-cycle strobe output or a level set by software.

A host reaches four byte locations through chip select, a two-bit register index and a read/write strobe. Each access lasts one clock cycle. Reads return combinational data in the same cycle. Any side effects of an access take hold at the clock edge that ends the cycle. The register bus is a plain register interface with no back-pressure: every cycle with `cs` high is exactly one access and is never stalled.

Each port drives its own active-low interrupt output. It is asserted while an enabled event flag of that port is set.

Top module: `pio_dual_adapter`

## Requirements
- R1: After reset, both direction registers and both control registers read 0. All pin and line-2 output enables are 0, and both interrupt outputs are high.
- R2: The register index selects the location: 0 is port A data or direction, 1 is port A control, 2 is port B data or direction, 3 is port B control. Control bit 2 picks data (1) or direction (0). A pin's output enable equals its direction bit. Its driven value is the written data bit.
- R3: A data read returns the written data bit for output pins and the live pin value for input pins.
- R4: Control bit 7 (flag 1) is set by the active edge of line 1. Control bit 1 picks the active edge: 1 for rising, 0 for falling. The other edge has no effect. Bits 7 and 6 are read-only, and writes to them are ignored.
- R5: The interrupt output of a port is low exactly while flag 1 is set with control bit 0 = 1, or flag 2 is set with control bit 3 = 1 and bit 5 = 0. A flag with its enable clear leaves the output high.
- R6: Reading a port's data register (bit 2 = 1) clears both flags of that port. Reading its control register or its direction register clears neither.
- R7: With control bit 5 = 0, line 2 is an input. Bit 4 picks its active edge (1 rising, 0 falling), that edge sets flag 2 (bit 6), and bit 3 enables its interrupt.
- R8: With control bits 5:3 = 100, line 2 is a handshake output that idles high. It goes low on the cycle after the triggering access and returns high after the next active edge of line 1. The triggering access is a data read on port A and a data write on port B.
- R9: With control bits 5:3 = 101, line 2 goes low for exactly one cycle after the same triggering access.
- R10: With control bits 5:4 = 11, line 2 drives the value of control bit 3. Its output enable is high whenever bit 5 = 1.
- R11: The ports are independent: events, accesses and flag clears on one port leave the other port's flags, interrupt and pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; one access per cycle while high |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 2 | Register index |
| wdata | input | W | Write data |
| rdata | output | W | Read data, 0 when not selected |
| pa_in | input | W | Port A pin values |
| pa_out | output | W | Port A driven values |
| pa_oe | output | W | Port A per-pin output enables |
| ca1 | input | 1 | Port A control line 1 |
| ca2_in | input | 1 | Port A control line 2 input |
| ca2_out | output | 1 | Port A control line 2 output value |
| ca2_oe | output | 1 | Port A control line 2 output enable |
| irqa_n | output | 1 | Port A interrupt, active low |
| pb_in | input | W | Port B pin values |
| pb_out | output | W | Port B driven values |
| pb_oe | output | W | Port B per-pin output enables |
| cb1 | input | 1 | Port B control line 1 |
| cb2_in | input | 1 | Port B control line 2 input |
| cb2_out | output | 1 | Port B control line 2 output value |
| cb2_oe | output | 1 | Port B control line 2 output enable |
| irqb_n | output | 1 | Port B interrupt, active low |

## Verification
Mixed direction masks with differing driven and pin values show whether each read bit comes from the output register or from the pin. Both edges are applied to each control line under each edge selection. This separates edge polarity from level sensitivity and shows flags raised without their enable. Each of the three read kinds is followed by an interrupt check, which tells a flag clear on the data read apart from one on control or direction reads. The same sequences run on the other port, which exposes the read-versus-write handshake trigger and any leakage between ports.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // control register bit positions
  localparam int C1_IRQ_EN  = 0;
  localparam int C1_RISE    = 1;
  localparam int DATA_SEL   = 2;
  localparam int C2_LO      = 3;
  localparam int C2_MID     = 4;
  localparam int C2_IS_OUT  = 5;
  localparam int FLAG2      = 6;
  localparam int FLAG1      = 7;
  localparam int CTL_W      = 8;
  localparam int CTL_WR_W   = 6;

  typedef enum logic [1:0] {
    C2_INPUT     = 2'd0,
    C2_HANDSHAKE = 2'd1,
    C2_PULSE     = 2'd2,
    C2_MANUAL    = 2'd3
  } c2_mode_e;

  function automatic c2_mode_e decode_c2(input logic [2:0] f);
    if (!f[2])      return C2_INPUT;
    else if (f[1])  return C2_MANUAL;
    else if (f[0])  return C2_PULSE;
    else            return C2_HANDSHAKE;
  endfunction
endpackage

// File: rtl/pio_edge_det.sv
module pio_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[TOP];
    end
  end

  assign rise = sync_q[TOP] & ~last_q;
  assign fall = ~sync_q[TOP] & last_q;
endmodule

// File: rtl/pio_ctl2.sv
module pio_ctl2
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_bits,
  input  logic       trig,
  input  logic       c1_act,
  output logic       c2_out,
  output logic       c2_oe
);
  c2_mode_e mode;
  logic     hs_q;
  logic     pulse_q;

  assign mode = decode_c2(mode_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b1;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= ~trig;
      if (mode != C2_HANDSHAKE) hs_q <= 1'b1;
      else if (trig)            hs_q <= 1'b0;
      else if (c1_act)          hs_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      C2_HANDSHAKE: c2_out = hs_q;
      C2_PULSE:     c2_out = pulse_q;
      C2_MANUAL:    c2_out = mode_bits[0];
      default:      c2_out = 1'b1;
    endcase
  end

  assign c2_oe = mode_bits[2];
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HS_ON_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rw,
  input  logic             reg_ctl,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_in,
  input  logic             c1,
  input  logic             c2_in,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic             c2_out,
  output logic             c2_oe,
  output logic             irq_n,
  output logic [CTL_W-1:0] ctl_view
);
  logic [W-1:0]        ddr_q, out_q;
  logic [CTL_WR_W-1:0] ctl_q;
  logic                f1_q, f2_q;
  logic                c1_rise, c1_fall, c2_rise, c2_fall;
  logic                c1_act, c2_act, c2_input;
  logic                rd_data, wr_data, wr_ddr, wr_ctl, trig;

  pio_edge_det #(.STAGES(SYNC_STAGES)) i_c1_edge (
    .clk(clk), .rst_n(rst_n), .pin(c1), .rise(c1_rise), .fall(c1_fall));
  pio_edge_det #(.STAGES(SYNC_STAGES)) i_c2_edge (
    .clk(clk), .rst_n(rst_n), .pin(c2_in), .rise(c2_rise), .fall(c2_fall));

  assign rd_data  = sel &  rw & ~reg_ctl &  ctl_q[DATA_SEL];
  assign wr_data  = sel & ~rw & ~reg_ctl &  ctl_q[DATA_SEL];
  assign wr_ddr   = sel & ~rw & ~reg_ctl & ~ctl_q[DATA_SEL];
  assign wr_ctl   = sel & ~rw &  reg_ctl;
  assign c1_act   = ctl_q[C1_RISE] ? c1_rise : c1_fall;
  assign c2_act   = ctl_q[C2_MID]  ? c2_rise : c2_fall;
  assign c2_input = ~ctl_q[C2_IS_OUT];

  generate
    if (HS_ON_WRITE) begin : g_trig_wr
      assign trig = wr_data;
    end else begin : g_trig_rd
      assign trig = rd_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr_q <= '0;
      out_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_ddr)  ddr_q <= wdata;
      if (wr_data) out_q <= wdata;
      if (wr_ctl)  ctl_q <= wdata[CTL_WR_W-1:0];
    end
  end

  // an event in the same cycle as a clearing read is kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f1_q <= 1'b0;
      f2_q <= 1'b0;
    end else begin
      if (c1_act)                f1_q <= 1'b1;
      else if (rd_data)          f1_q <= 1'b0;
      if (c2_act && c2_input)    f2_q <= 1'b1;
      else if (rd_data)          f2_q <= 1'b0;
    end
  end

  pio_ctl2 i_ctl2 (
    .clk(clk), .rst_n(rst_n), .mode_bits(ctl_q[C2_IS_OUT:C2_LO]),
    .trig(trig), .c1_act(c1_act), .c2_out(c2_out), .c2_oe(c2_oe));

  assign ctl_view = {f1_q, f2_q, ctl_q};

  always_comb begin
    rdata = '0;
    if (reg_ctl)                 rdata[CTL_W-1:0] = ctl_view;
    else if (ctl_q[DATA_SEL])    rdata = (out_q & ddr_q) | (pin_in & ~ddr_q);
    else                         rdata = ddr_q;
  end

  assign pin_out = out_q;
  assign pin_oe  = ddr_q;
  assign irq_n   = ~((f1_q & ctl_q[C1_IRQ_EN]) |
                     (f2_q & ctl_q[C2_LO] & c2_input));
endmodule

// File: rtl/pio_dual_adapter.sv
module pio_dual_adapter
  import pio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rw,
  input  logic [1:0]   rs,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic         ca1,
  input  logic         ca2_in,
  output logic         ca2_out,
  output logic         ca2_oe,
  output logic         irqa_n,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic         cb1,
  input  logic         cb2_in,
  output logic         cb2_out,
  output logic         cb2_oe,
  output logic         irqb_n
);
  localparam int NPORT = 2;

  logic [NPORT-1:0][W-1:0]     pin_in_v, pin_out_v, pin_oe_v, rdata_v;
  logic [NPORT-1:0][CTL_W-1:0] ctl_view;
  logic [NPORT-1:0]            c1_v, c2_in_v, c2_out_v, c2_oe_v, irq_n_v;

  assign pin_in_v = {pb_in, pa_in};
  assign c1_v     = {cb1, ca1};
  assign c2_in_v  = {cb2_in, ca2_in};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port #(
      .W(W), .SYNC_STAGES(SYNC_STAGES), .HS_ON_WRITE(p == 1)
    ) i_port (
      .clk(clk), .rst_n(rst_n),
      .sel(cs && (rs[1] == 1'(p))), .rw(rw), .reg_ctl(rs[0]),
      .wdata(wdata), .pin_in(pin_in_v[p]), .c1(c1_v[p]), .c2_in(c2_in_v[p]),
      .rdata(rdata_v[p]), .pin_out(pin_out_v[p]), .pin_oe(pin_oe_v[p]),
      .c2_out(c2_out_v[p]), .c2_oe(c2_oe_v[p]), .irq_n(irq_n_v[p]),
      .ctl_view(ctl_view[p]));
  end

  assign rdata   = cs ? rdata_v[rs[1]] : '0;
  assign pa_out  = pin_out_v[0];
  assign pa_oe   = pin_oe_v[0];
  assign pb_out  = pin_out_v[1];
  assign pb_oe   = pin_oe_v[1];
  assign ca2_out = c2_out_v[0];
  assign ca2_oe  = c2_oe_v[0];
  assign cb2_out = c2_out_v[1];
  assign cb2_oe  = c2_oe_v[1];
  assign irqa_n  = irq_n_v[0];
  assign irqb_n  = irq_n_v[1];
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs,
  input logic         rw,
  input logic [1:0]   rs,
  input logic [7:0]   ctl_a,
  input logic [7:0]   ctl_b,
  input logic [W-1:0] pa_oe,
  input logic         ca2_out,
  input logic         irqa_n,
  input logic         irqb_n
);
  a_r2_oe_only_by_ddr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe != $past(pa_oe)) |-> $past(cs && !rw && rs == 2'd0 && !ctl_a[2]));

  a_r5_irqa_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irqa_n |-> (ctl_a[7] || ctl_a[6]));

  a_r5_irqb_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irqb_n |-> (ctl_b[7] || ctl_b[6]));

  a_r8_handshake_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw && rs == 2'd0 && ctl_a[2] && ctl_a[5:3] == 3'b100) |=> !ca2_out);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_a[5:3] == 3'b101 && !ca2_out && !(cs && rs[1] == 1'b0)) |=> ca2_out);
endmodule

bind pio_dual_adapter pio_checker #(.W(W)) i_pio_checker (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .rs(rs),
  .ctl_a(ctl_view[0]), .ctl_b(ctl_view[1]), .pa_oe(pa_oe),
  .ca2_out(ca2_out), .irqa_n(irqa_n), .irqb_n(irqb_n));

// File: tb/test_pio_dual_adapter.sv
module test_pio_dual_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, rw = 1'b1;
  logic [1:0] rs = '0;
  logic [W-1:0] wdata = '0, rdata, pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
  logic ca1 = 1'b0, ca2_in = 1'b0, ca2_out, ca2_oe, irqa_n;
  logic cb1 = 1'b0, cb2_in = 1'b0, cb2_out, cb2_oe, irqb_n;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_dual_adapter #(.W(W)) i_pio_dual_adapter (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .rs(rs), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .ca1(ca1), .ca2_in(ca2_in),
    .ca2_out(ca2_out), .ca2_oe(ca2_oe), .irqa_n(irqa_n),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .cb1(cb1), .cb2_in(cb2_in),
    .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irqb_n(irqb_n));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b0; rs = a; wdata = d;
    @(negedge clk); cs = 1'b0; rw = 1'b1;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b1; rs = a;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", "pa_oe", pa_oe, 0);
    check("R1", "pb_oe", pb_oe, 0);
    check("R1", "line2 oe", {ca2_oe, cb2_oe}, 0);
    check("R1", "irq", {irqa_n, irqb_n}, 2'b11);
    bus_rd(2'd1, d); check("R1", "ctl A", d, 8'h00);
    bus_rd(2'd3, d); check("R1", "ctl B", d, 8'h00);
    bus_rd(2'd0, d); check("R1", "ddr A", d, 8'h00);
  endtask

  task automatic t_ddr_read();
    logic [7:0] d;
    bus_wr(2'd0, 8'h0F); check("R2", "pa_oe from ddr", pa_oe, 8'h0F);
    bus_wr(2'd1, 8'h04); bus_wr(2'd0, 8'hA5);
    check("R2", "pa_out", pa_out, 8'hA5);
    check("R2", "pa_oe unchanged by data write", pa_oe, 8'h0F);
    pa_in = 8'h3C;
    bus_rd(2'd0, d); check("R3", "port A mixed read", d, 8'h35);
    bus_wr(2'd1, 8'h00); bus_rd(2'd0, d); check("R2", "ddr A readback", d, 8'h0F);
    bus_wr(2'd1, 8'h04);
    bus_wr(2'd2, 8'hF0); bus_wr(2'd3, 8'h04); bus_wr(2'd2, 8'h5A);
    pb_in = 8'h81;
    check("R2", "pb_oe", pb_oe, 8'hF0);
    bus_rd(2'd2, d); check("R3", "port B mixed read", d, 8'h51);
  endtask

  task automatic t_c1_edges();
    logic [7:0] d;
    bus_wr(2'd1, 8'h04);           // falling active, no irq
    ca1 = 1'b1; idle(4);
    bus_rd(2'd1, d); check("R4", "rising ignored when falling selected", d, 8'h04);
    ca1 = 1'b0; idle(4);
    bus_rd(2'd1, d); check("R4", "falling sets flag1", d, 8'h84);
    check("R5", "no irq without enable", irqa_n, 1'b1);
    bus_rd(2'd0, d);
    bus_wr(2'd1, 8'hC4);
    bus_rd(2'd1, d); check("R4", "flag bits not writable", d, 8'h04);
  endtask

  task automatic t_irq_clear();
    logic [7:0] d;
    bus_wr(2'd1, 8'h07);           // irq en, rising, data
    ca1 = 1'b1; idle(4);
    check("R5", "irqa asserted", irqa_n, 1'b0);
    bus_rd(2'd1, d); check("R4", "flag1 visible", d, 8'h87);
    check("R6", "ctl read keeps flag", irqa_n, 1'b0);
    bus_wr(2'd1, 8'h03); bus_rd(2'd0, d);
    check("R6", "ddr read keeps flag", irqa_n, 1'b0);
    bus_wr(2'd1, 8'h07); bus_rd(2'd0, d);
    check("R6", "data read clears flag", irqa_n, 1'b1);
    ca1 = 1'b0; idle(4);
    check("R4", "inactive edge no irq", irqa_n, 1'b1);
  endtask

  task automatic t_c2_input();
    logic [7:0] d;
    bus_wr(2'd1, 8'h1C);           // line2 in, rising, en
    check("R7", "ca2_oe low in input mode", ca2_oe, 1'b0);
    ca2_in = 1'b1; idle(4);
    check("R7", "line2 edge irq", irqa_n, 1'b0);
    bus_rd(2'd1, d); check("R7", "flag2 set", d, 8'h5C);
    bus_rd(2'd0, d); check("R6", "flag2 cleared", irqa_n, 1'b1);
    ca2_in = 1'b0; idle(4);
    bus_rd(2'd1, d); check("R7", "falling ignored", d, 8'h1C);
  endtask

  task automatic t_handshake();
    logic [7:0] d;
    bus_wr(2'd1, 8'h26);           // handshake, line1 rising
    check("R8", "ca2 idle high", {ca2_oe, ca2_out}, 2'b11);
    bus_rd(2'd0, d); check("R8", "ca2 low after read", ca2_out, 1'b0);
    idle(3); check("R8", "ca2 held low", ca2_out, 1'b0);
    ca1 = 1'b1; idle(4); check("R8", "ca2 back high on ca1", ca2_out, 1'b1);
    ca1 = 1'b0; idle(2);
    bus_wr(2'd3, 8'h26);
    bus_rd(2'd2, d); check("R8", "cb2 ignores read", cb2_out, 1'b1);
    bus_wr(2'd2, 8'h11); check("R8", "cb2 low after write", cb2_out, 1'b0);
    cb1 = 1'b1; idle(4); check("R8", "cb2 back high on cb1", cb2_out, 1'b1);
    cb1 = 1'b0; idle(4);
    bus_rd(2'd2, d);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    bus_wr(2'd1, 8'h2C);
    bus_rd(2'd0, d); check("R9", "ca2 pulse low", ca2_out, 1'b0);
    idle(1); check("R9", "ca2 pulse one cycle", ca2_out, 1'b1);
    bus_wr(2'd3, 8'h2C);
    bus_wr(2'd2, 8'h22); check("R9", "cb2 pulse low", cb2_out, 1'b0);
    idle(1); check("R9", "cb2 pulse one cycle", cb2_out, 1'b1);
  endtask

  task automatic t_manual();
    bus_wr(2'd1, 8'h34); check("R10", "ca2 manual low", {ca2_oe, ca2_out}, 2'b10);
    bus_wr(2'd1, 8'h3C); check("R10", "ca2 manual high", {ca2_oe, ca2_out}, 2'b11);
  endtask

  task automatic t_independent();
    logic [7:0] d;
    bus_wr(2'd1, 8'h07); bus_wr(2'd3, 8'h07);
    ca1 = 1'b1; idle(4);
    check("R11", "irqb unaffected by ca1", irqb_n, 1'b1);
    bus_rd(2'd3, d); check("R11", "ctl B flags clear", d, 8'h07);
    bus_wr(2'd1, 8'h03); bus_wr(2'd0, 8'hFF);
    check("R11", "pb_oe unaffected", pb_oe, 8'hF0);
    bus_wr(2'd1, 8'h07); bus_rd(2'd0, d);
    cb1 = 1'b1; idle(4);
    check("R11", "irqb asserted", irqb_n, 1'b0);
    bus_rd(2'd0, d); check("R11", "port A read keeps B flag", irqb_n, 1'b0);
    bus_rd(2'd2, d); check("R6", "port B read clears", irqb_n, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4); rst_n = 1'b1; idle(2);
    t_reset();
    t_ddr_read();
    t_c1_edges();
    t_irq_clear();
    t_c2_input();
    t_handshake();
    t_pulse();
    t_manual();
    t_independent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule